// File: doc/BRIEF.md
# Dual Signed Multiply-Accumulate Unit

This execution unit carries out one instruction: two signed 16x16 halfword multiplications whose products are summed into a 32-bit accumulator. It takes a 32-bit instruction word and decodes the register fields and the exchange bit. It drives three register-file read addresses and gets the operand values back on the same cycle. One cycle later it returns the 32-bit result, the destination register index and a sticky overflow flag.

The two products pair the halfwords of the first operand with those of the second operand. Normally low pairs with low and high with high. When the exchange bit is set, the halfwords of the second operand are crossed over first. An accumulator index of 15 selects a form that adds the two products only, with no accumulator. If an instruction word does not match the fixed opcode bits, the unit reports it as not this instruction. If an instruction names register 15 as destination or as a multiply source, the unit reports it as unpredictable. In both cases the unit executes nothing.

Top module: `dmac_unit`

## Requirements
- R1: After reset `out_valid` is 0 and `q_flag` is 0.
- R2: `out_valid` is 1 in the cycle after each cycle with `in_valid` high, and 0 otherwise.
- R3: With exchange bit 5 at 0, the result is the low 32 bits of acc + Rn[15:0]*Rm[15:0] + Rn[31:16]*Rm[31:16], with all halfwords signed. Rn sits in bits [3:0], Rm in bits [11:8] and the accumulator index in bits [15:12].
- R4: With bit 5 at 1, the result is the low 32 bits of acc + Rn[15:0]*Rm[31:16] + Rn[31:16]*Rm[15:0].
- R5: When bits [15:12] equal 15, the accumulator value is ignored and the result is the sum of the two products only.
- R6: `q_flag` is set by an executed instruction whose exact sum lies outside the signed 32-bit range. This includes two (-32768)*(-32768) products with a zero accumulator, or with no accumulator. Nothing else sets it.
- R7: `q_flag` stays set until `q_clear` is high at a clock edge. If an overflow happens on the same edge as a clear, the flag ends up set.
- R8: If bits [27:20] differ from 0x70, or bits [7:6] are not 00, or bit 4 is not 1, the output shows `out_illegal`=1 and `out_result`=0, and `q_flag` is not changed.
- R9: For a word that passes the opcode test but has 15 in bits [19:16], [3:0] or [11:8], the output shows `out_unpred`=1, `out_illegal`=0 and `out_result`=0, and `q_flag` is not changed.
- R10: `out_dest` equals bits [19:16] of the accepted word.
- R11: The read addresses are driven combinationally: `rf_addr_n`=bits [3:0], `rf_addr_m`=bits [11:8] and `rf_addr_a`=bits [15:12]. The condition field, bits [31:28], has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word present this cycle |
| in_instr | input | 32 | Instruction word |
| q_clear | input | 1 | Clears the sticky overflow flag |
| rf_addr_n | output | 4 | Read address, first multiply operand |
| rf_addr_m | output | 4 | Read address, second multiply operand |
| rf_addr_a | output | 4 | Read address, accumulator |
| rf_data_n | input | 32 | Value of the first operand register |
| rf_data_m | input | 32 | Value of the second operand register |
| rf_data_a | input | 32 | Value of the accumulator register |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_result | output | 32 | Wrapped 32-bit result, 0 for rejected words |
| out_dest | output | 4 | Destination register index |
| out_illegal | output | 1 | Opcode bits do not match |
| out_unpred | output | 1 | Register 15 used where not allowed |
| q_flag | output | 1 | Sticky overflow flag |

## Verification
The only internal state is the registered result stage and the sticky flag, so any fault shows at the ports within one cycle. A wrong lane pairing or a wrong sign extension corrupts `out_result` on the strobe that follows the instruction. A flag that sets on the wrong sum, fails to stay set, or fails to clear shows on `q_flag` at the next edge. After that the fault persists, so every later comparison exposes it. The bench compares the strobe and the flag on every clock, and compares the payload on every strobe.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int INSTR_W  = 32;
  localparam int REG_AW   = 4;
  localparam logic [REG_AW-1:0] REG_PC = 4'd15;
  localparam logic [7:0] OPC_MAJOR = 8'h70;

  localparam int F_RD_LSB = 16;
  localparam int F_RA_LSB = 12;
  localparam int F_RM_LSB = 8;
  localparam int F_RN_LSB = 0;
  localparam int F_SWAP   = 5;
  localparam int F_ONE    = 4;

  typedef struct packed {
    logic [REG_AW-1:0] rd;
    logic [REG_AW-1:0] ra;
    logic [REG_AW-1:0] rm;
    logic [REG_AW-1:0] rn;
    logic              swap;
    logic              no_acc;
    logic              illegal;
    logic              unpred;
  } dmac_fields_t;
endpackage

// File: rtl/dmac_decode.sv
module dmac_decode
  import dmac_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output dmac_fields_t       fields
);
  logic opc_ok;
  logic uses_pc;

  // fixed bits: major opcode, two zero bits, one set bit
  assign opc_ok = (instr[27:20] == OPC_MAJOR) &&
                  (instr[7:6] == 2'b00) &&
                  instr[F_ONE];

  assign uses_pc = (instr[F_RD_LSB +: REG_AW] == REG_PC) ||
                   (instr[F_RN_LSB +: REG_AW] == REG_PC) ||
                   (instr[F_RM_LSB +: REG_AW] == REG_PC);

  always_comb begin
    fields.rd      = instr[F_RD_LSB +: REG_AW];
    fields.ra      = instr[F_RA_LSB +: REG_AW];
    fields.rm      = instr[F_RM_LSB +: REG_AW];
    fields.rn      = instr[F_RN_LSB +: REG_AW];
    fields.swap    = instr[F_SWAP];
    fields.no_acc  = (instr[F_RA_LSB +: REG_AW] == REG_PC);
    fields.illegal = !opc_ok;
    fields.unpred  = opc_ok && uses_pc;
  end
endmodule

// File: rtl/dmac_mac.sv
module dmac_mac #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] op_n,
  input  logic [DATA_W-1:0] op_m,
  input  logic [DATA_W-1:0] acc,
  input  logic              swap,
  input  logic              use_acc,
  output logic [DATA_W-1:0] result,
  output logic              ovf
);
  localparam int HALF_W = DATA_W / 2;
  localparam int PROD_W = DATA_W;
  localparam int SUM_W  = DATA_W + 2;
  localparam int LANES  = 2;
  localparam int TOP_W  = SUM_W - DATA_W + 1;

  function automatic logic signed [PROD_W-1:0] smul(input logic [HALF_W-1:0] a,
                                                    input logic [HALF_W-1:0] b);
    logic signed [PROD_W-1:0] ea;
    logic signed [PROD_W-1:0] eb;
    ea = {{(PROD_W-HALF_W){a[HALF_W-1]}}, a};
    eb = {{(PROD_W-HALF_W){b[HALF_W-1]}}, b};
    return ea * eb;
  endfunction

  function automatic logic [SUM_W-1:0] widen(input logic [DATA_W-1:0] v);
    return {{(SUM_W-DATA_W){v[DATA_W-1]}}, v};
  endfunction

  // the bits above the result's sign must all copy it
  function automatic logic out_of_range(input logic [SUM_W-1:0] s);
    logic [TOP_W-1:0] top;
    top = s[SUM_W-1:DATA_W-1];
    return !((&top) || !(|top));
  endfunction

  logic [PROD_W-1:0] prod [LANES];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [HALF_W-1:0] a_h;
    logic [HALF_W-1:0] b_h;
    assign a_h = op_n[i*HALF_W +: HALF_W];
    assign b_h = swap ? op_m[(LANES-1-i)*HALF_W +: HALF_W]
                      : op_m[i*HALF_W +: HALF_W];
    assign prod[i] = smul(a_h, b_h);
  end

  logic [SUM_W-1:0] acc_w;
  logic [SUM_W-1:0] sum;

  assign acc_w  = use_acc ? widen(acc) : '0;
  assign sum    = widen(prod[0]) + widen(prod[1]) + acc_w;
  assign result = sum[DATA_W-1:0];
  assign ovf    = out_of_range(sum);
endmodule

// File: rtl/dmac_qreg.sv
module dmac_qreg (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic set,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= 1'b0;
    else        q <= (q & ~clear) | set;
  end
endmodule

// File: rtl/dmac_unit.sv
module dmac_unit
  import dmac_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [INSTR_W-1:0] in_instr,
  input  logic              q_clear,
  output logic [REG_AW-1:0] rf_addr_n,
  output logic [REG_AW-1:0] rf_addr_m,
  output logic [REG_AW-1:0] rf_addr_a,
  input  logic [DATA_W-1:0] rf_data_n,
  input  logic [DATA_W-1:0] rf_data_m,
  input  logic [DATA_W-1:0] rf_data_a,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_result,
  output logic [REG_AW-1:0] out_dest,
  output logic              out_illegal,
  output logic              out_unpred,
  output logic              q_flag
);
  dmac_fields_t       fields;
  logic [DATA_W-1:0]  mac_result;
  logic               mac_ovf;
  logic               exec_fire;
  logic               exec_ovf;

  dmac_decode u_dec (
    .instr  (in_instr),
    .fields (fields)
  );

  assign rf_addr_n = fields.rn;
  assign rf_addr_m = fields.rm;
  assign rf_addr_a = fields.ra;

  dmac_mac #(.DATA_W(DATA_W)) u_mac (
    .op_n    (rf_data_n),
    .op_m    (rf_data_m),
    .acc     (rf_data_a),
    .swap    (fields.swap),
    .use_acc (!fields.no_acc),
    .result  (mac_result),
    .ovf     (mac_ovf)
  );

  // named events for the checker
  assign exec_fire = in_valid && !fields.illegal && !fields.unpred;
  assign exec_ovf  = exec_fire && mac_ovf;

  dmac_qreg u_q (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (q_clear),
    .set   (exec_ovf),
    .q     (q_flag)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_dest    <= '0;
      out_illegal <= 1'b0;
      out_unpred  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result  <= exec_fire ? mac_result : '0;
        out_dest    <= fields.rd;
        out_illegal <= fields.illegal;
        out_unpred  <= fields.unpred;
      end
    end
  end
endmodule

// File: rtl/dmac_checker.sv
module dmac_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              q_clear,
  input logic              exec_ovf,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_result,
  input logic              out_illegal,
  input logic              out_unpred,
  input logic              q_flag
);
  AST_OUT_FOLLOWS_IN: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R2
  AST_NO_SPURIOUS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R2
  AST_Q_ONLY_ON_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!q_flag && !exec_ovf) |=> !q_flag); // R6
  AST_Q_SET_ON_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    exec_ovf |=> q_flag); // R6
  AST_Q_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (q_flag && !q_clear) |=> q_flag); // R7
  AST_Q_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (q_clear && !exec_ovf) |=> !q_flag); // R7
  AST_REJECT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_illegal || out_unpred)) |-> (out_result == '0)); // R8
  AST_REJECT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_illegal && out_unpred)); // R9
endmodule

bind dmac_unit dmac_checker #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .q_clear     (q_clear),
  .exec_ovf    (exec_ovf),
  .out_valid   (out_valid),
  .out_result  (out_result),
  .out_illegal (out_illegal),
  .out_unpred  (out_unpred),
  .q_flag      (q_flag)
);

// File: tb/dmac_unit_tb.sv
module dmac_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_instr = '0;
  logic        q_clear = 1'b0;
  logic [3:0]  rf_addr_n, rf_addr_m, rf_addr_a;
  logic [31:0] rf_data_n, rf_data_m, rf_data_a;
  logic        out_valid, out_illegal, out_unpred, q_flag;
  logic [31:0] out_result;
  logic [3:0]  out_dest;

  logic [31:0] regs [16];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  bit q_model = 0;

  always #5 clk = ~clk;

  assign rf_data_n = regs[rf_addr_n];
  assign rf_data_m = regs[rf_addr_m];
  assign rf_data_a = regs[rf_addr_a];

  dmac_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
    .q_clear(q_clear), .rf_addr_n(rf_addr_n), .rf_addr_m(rf_addr_m),
    .rf_addr_a(rf_addr_a), .rf_data_n(rf_data_n), .rf_data_m(rf_data_m),
    .rf_data_a(rf_data_a), .out_valid(out_valid), .out_result(out_result),
    .out_dest(out_dest), .out_illegal(out_illegal), .out_unpred(out_unpred),
    .q_flag(q_flag)
  );

  task automatic check(string req, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  function automatic logic [31:0] mk(logic [3:0] cnd, logic [3:0] rd, logic [3:0] ra,
                                     logic [3:0] rm, logic xbit, logic [3:0] rn);
    return {cnd, 8'b0111_0000, rd, ra, rm, 2'b00, xbit, 1'b1, rn};
  endfunction

  function automatic longint shalf(logic [15:0] h);
    longint v = longint'(h);
    if (v >= 32768) v = v - 65536;
    return v;
  endfunction

  function automatic longint sword(logic [31:0] w);
    longint v = longint'(w);
    if (v >= 64'sd2147483648) v = v - 64'sd4294967296;
    return v;
  endfunction

  // one clock: drive at negedge, compare at the next negedge
  task automatic step(bit v, logic [31:0] w, bit clr, string req);
    bit bad_opc, uses15, runs, ovf;
    longint s, a;
    logic [31:0] n, m, exp_res;
    in_valid = v; in_instr = w; q_clear = clr;
    bad_opc = (w[27:20] !== 8'h70) || (w[7:6] != 2'b00) || !w[4];
    uses15  = !bad_opc && (w[19:16] == 15 || w[3:0] == 15 || w[11:8] == 15);
    runs = v && !bad_opc && !uses15;
    n = regs[w[3:0]]; m = regs[w[11:8]];
    a = (w[15:12] == 15) ? 0 : sword(regs[w[15:12]]);
    if (w[5]) s = shalf(n[15:0]) * shalf(m[31:16]) + shalf(n[31:16]) * shalf(m[15:0]) + a;
    else      s = shalf(n[15:0]) * shalf(m[15:0]) + shalf(n[31:16]) * shalf(m[31:16]) + a;
    ovf = (s > 64'sd2147483647) || (s < -64'sd2147483648);
    exp_res = runs ? s[31:0] : 32'h0;
    #1;
    if (v) begin
      check({"R11 addr_n ", req}, rf_addr_n, w[3:0]);
      check({"R11 addr_m ", req}, rf_addr_m, w[11:8]);
      check({"R11 addr_a ", req}, rf_addr_a, w[15:12]);
    end
    q_model = (q_model && !clr) || (runs && ovf);
    @(posedge clk); @(negedge clk);
    check({"R2 valid ", req}, out_valid, v);
    check({"R7 q ", req}, q_flag, q_model);
    if (v) begin
      check({"R3 result ", req}, out_result, exp_res);
      check({"R10 dest ", req}, out_dest, w[19:16]);
      check({"R8 illegal ", req}, out_illegal, bad_opc);
      check({"R9 unpred ", req}, out_unpred, uses15);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end

  initial begin
    for (int i = 0; i < 16; i++) regs[i] = 32'h1111_0000 * i + i;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 valid after reset", out_valid, 0);
    check("R1 q after reset", q_flag, 0);

    regs[1] = 32'h0003_0002; regs[2] = 32'h0005_0004; regs[3] = 32'd100;
    step(1, mk(4'hE, 4'd4, 4'd3, 4'd2, 1'b0, 4'd1), 0, "R3 basic");
    step(1, mk(4'h0, 4'd5, 4'd3, 4'd2, 1'b0, 4'd1), 0, "R11 cond ignored");
    step(1, mk(4'hE, 4'd6, 4'd3, 4'd2, 1'b1, 4'd1), 0, "R4 exchange");
    regs[5] = 32'hFFFD_8000; regs[6] = 32'h7FFF_FFFF; regs[7] = 32'hFFFF_FF00;
    step(1, mk(4'hE, 4'd0, 4'd7, 4'd6, 1'b0, 4'd5), 0, "R3 negatives");
    step(1, mk(4'hE, 4'd0, 4'd7, 4'd6, 1'b1, 4'd5), 0, "R4 negatives");
    regs[15] = 32'h1234_5678;
    step(1, mk(4'hE, 4'd8, 4'd15, 4'd2, 1'b0, 4'd1), 0, "R5 no accumulate");
    step(0, 32'h0, 0, "R2 idle");
    check("R6 q still clear", q_flag, 0);

    regs[8] = 32'h8000_8000; regs[9] = 32'h0;
    step(1, mk(4'hE, 4'd1, 4'd9, 4'd8, 1'b0, 4'd8), 0, "R6 maxneg zero acc");
    check("R6 q after maxneg", q_flag, 1);
    step(1, mk(4'hE, 4'd1, 4'd3, 4'd2, 1'b0, 4'd1), 0, "R7 sticky");
    step(0, 32'h0, 1, "R7 clear");
    check("R7 q cleared", q_flag, 0);
    step(1, mk(4'hE, 4'd1, 4'd15, 4'd8, 1'b1, 4'd8), 0, "R6 maxneg no acc");
    step(1, mk(4'hE, 4'd1, 4'd9, 4'd8, 1'b0, 4'd8), 1, "R7 clear with overflow");
    check("R7 set wins", q_flag, 1);
    step(0, 32'h0, 1, "R7 clear again");

    regs[10] = 32'h7FFF_FFFF; regs[11] = 32'h0000_0001; regs[12] = 32'h0001_0001;
    step(1, mk(4'hE, 4'd2, 4'd10, 4'd12, 1'b0, 4'd11), 0, "R6 acc wrap");
    step(0, 32'h0, 1, "R7 clear 3");
    step(1, mk(4'hE, 4'd2, 4'd10, 4'd12, 1'b0, 4'd11) & ~32'h10, 0, "R8 bit4 clear");
    step(1, mk(4'hE, 4'd2, 4'd9, 4'd8, 1'b0, 4'd8) ^ 32'h0100_0000, 0, "R8 opcode");
    step(1, mk(4'hE, 4'd2, 4'd9, 4'd8, 1'b0, 4'd8) | 32'h40, 0, "R8 bit6 set");
    check("R8 q unchanged", q_flag, 0);
    step(1, mk(4'hE, 4'd15, 4'd9, 4'd8, 1'b0, 4'd8), 0, "R9 rd pc");
    step(1, mk(4'hE, 4'd1, 4'd9, 4'd8, 1'b0, 4'd15), 0, "R9 rn pc");
    step(1, mk(4'hE, 4'd1, 4'd9, 4'd15, 1'b0, 4'd8), 0, "R9 rm pc");
    check("R9 q unchanged", q_flag, 0);

    for (int k = 0; k < 60; k++) begin
      logic [3:0] ra;
      for (int j = 0; j < 15; j++) regs[j] = $urandom;
      ra = ($urandom_range(0, 5) == 0) ? 4'd15 : 4'($urandom_range(0, 14));
      step(1, mk(4'($urandom), 4'($urandom_range(0, 14)), ra, 4'($urandom_range(0, 14)),
                 1'($urandom), 4'($urandom_range(0, 14))),
           ($urandom_range(0, 3) == 0), "R3 random");
    end
    step(0, 32'h0, 0, "R2 tail");
    summary();
  end
endmodule